// File: doc/BRIEF.md
# Pipelined Long-Distance FIFO Channel

This block carries a stream of words between two modules that sit far apart on a large device. The wire between them crosses one or more region boundaries. At each boundary a fixed number of plain register levels is inserted, so no combinational path spans the distance. The write strobe and data travel forward through those registers. The storage's fill warning travels back through the same number of registers to the producer.

Because the producer sees its full flag late, the storage raises that flag early. The threshold is fixed at elaboration from the total number of inserted levels. It covers the words already in flight plus the words the producer may still send before the delayed flag reaches it. As a result, the extra latency never drops or duplicates a word.

The consumer sees a first-word-fall-through interface. The storage is built either as a shift register or as a pointer-addressed ring, and a parameter chooses between them by depth. A channel may be given extra levels purely to match the latency of a parallel path; the word sequence delivered stays the same.

Top module: `xr_channel`

## Requirements
- R1: After synchronous active-low reset, `rd_empty` is 1 and `wr_full` is 0, all forward valid registers are cleared and the storage holds no words.
- R2: A word is accepted exactly at a rising edge where `wr_en` is 1 and `wr_full` is 0. A write attempted while `wr_full` is 1 is ignored and never reaches the consumer.
- R3: With S = CROSSINGS x LEVELS_PER_CROSSING register levels, the storage warns when its fill level is at least DEPTH - 2S. The storage never holds more than DEPTH words. Writing on every cycle from empty with no reads, exactly DEPTH words are accepted.
- R4: A word accepted at edge E into an empty channel makes `rd_empty` fall at edge E+S, not earlier.
- R5: When reads bring the fill level below DEPTH - 2S at edge E, `wr_full` falls at edge E+S.
- R6: Words leave in the order they were accepted, with none lost or duplicated. While `rd_empty` is 0, `rd_data` shows the oldest stored word and holds it until it is read.
- R7: A read requested while `rd_empty` is 1 is ignored and does not consume a word that arrives later.
- R8: The shift-register storage (DEPTH <= SHIFT_MAX_DEPTH) and the ring storage give identical port behaviour cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Producer write request |
| wr_data | input | DATA_W | Producer word |
| wr_full | output | 1 | Delayed early-full flag seen by the producer |
| rd_en | input | 1 | Consumer read request |
| rd_data | output | DATA_W | Oldest stored word (fall-through) |
| rd_empty | output | 1 | No word stored |

## Verification
An accepted word reaches storage S edges after its acceptance edge, so the bench looks for `rd_empty` to still be 1 after S-1 further edges and 0 after S. A fill warning crossing reaches `wr_full` S edges later, checked the same way on both sides of that edge. Inputs are driven and outputs sampled on the falling clock edge, so each sample sees the state left by the preceding rising edge. A shift-style and a ring-style instance run under identical stimulus and are compared every cycle against each other and against a bench queue of accepted words.

// File: rtl/xr_channel_pkg.sv
// Package: shared storage-style type and the rule that picks a style.
package xr_channel_pkg;

    typedef enum logic {
        STORE_SHIFT = 1'b0,
        STORE_RING  = 1'b1
    } store_style_e;

    // Small channels use a shift register, larger ones a pointer-addressed ring.
    function automatic store_style_e pick_style(input int depth, input int shift_max);
        return (depth <= shift_max) ? STORE_SHIFT : STORE_RING;
    endfunction

endpackage

// File: rtl/xr_delay_line.sv
// Module: xr_delay_line
// Delays a bus by N plain register stages; N = 0 gives a straight wire.
// Assumes: all stages clear to zero on synchronous active-low reset.
module xr_delay_line #(
    parameter int W = 1,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (N == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] stage [N];

            // Shift the bus one stage further on each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < N; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= din;
                    for (int i = 1; i < N; i++) stage[i] <= stage[i-1];
                end
            end

            assign dout = stage[N-1];
        end
    endgenerate

endmodule

// File: rtl/xr_store.sv
// Module: xr_store
// First-word-fall-through storage with a fill counter and an early-full warning.
// Assumes: the writer never writes when full (guaranteed by the threshold),
// reads are only requested when not empty.
module xr_store
    import xr_channel_pkg::*;
#(
    parameter int           DATA_W   = 32,
    parameter int           DEPTH    = 16,
    parameter int           AF_LEVEL = 8,
    parameter store_style_e STYLE    = STORE_SHIFT,
    localparam int          ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int          CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_full,
    output logic [CNT_W-1:0]  fill
);

    // Track how many words are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else begin
            case ({wr_valid, rd_take})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign empty       = (fill == '0);
    assign almost_full = (fill >= CNT_W'(AF_LEVEL));

    generate
        if (STYLE == STORE_SHIFT) begin : g_shift
            logic [DATA_W-1:0] sreg [DEPTH];
            logic [ADDR_W-1:0] head;

            // Push each new word in at the bottom; older words move up.
            always_ff @(posedge clk) begin
                if (wr_valid) begin
                    sreg[0] <= wr_data;
                    for (int i = 1; i < DEPTH; i++) sreg[i] <= sreg[i-1];
                end
            end

            assign head    = empty ? '0 : ADDR_W'(fill - CNT_W'(1));
            assign rd_data = sreg[head];
        end else begin : g_ring
            logic [DATA_W-1:0] mem [DEPTH];
            logic [ADDR_W-1:0] wr_ptr;
            logic [ADDR_W-1:0] rd_ptr;

            // Write the incoming word at the write pointer.
            always_ff @(posedge clk) begin
                if (wr_valid) mem[wr_ptr] <= wr_data;
            end

            // Advance both pointers with wrap at DEPTH.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wr_ptr <= '0;
                    rd_ptr <= '0;
                end else begin
                    if (wr_valid)
                        wr_ptr <= (wr_ptr == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr + ADDR_W'(1);
                    if (rd_take)
                        rd_ptr <= (rd_ptr == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr + ADDR_W'(1);
                end
            end

            assign rd_data = mem[rd_ptr];
        end
    endgenerate

endmodule

// File: rtl/xr_channel.sv
// Module: xr_channel (top)
// Long-distance FIFO channel: forward write strobe/data and backward full flag
// each pass through STAGES register levels; storage warns early by 2*STAGES.
// Assumes: DEPTH > 2 * CROSSINGS * LEVELS_PER_CROSSING.
module xr_channel
    import xr_channel_pkg::*;
#(
    parameter int DATA_W              = 32,
    parameter int DEPTH               = 16,
    parameter int CROSSINGS           = 2,
    parameter int LEVELS_PER_CROSSING = 2,
    parameter int SHIFT_MAX_DEPTH     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int           STAGES   = CROSSINGS * LEVELS_PER_CROSSING;
    localparam int           AF_LEVEL = DEPTH - 2 * STAGES;
    localparam int           CNT_W    = $clog2(DEPTH + 1);
    localparam store_style_e STYLE    = pick_style(DEPTH, SHIFT_MAX_DEPTH);

    logic              accept;
    logic              arr_valid;
    logic [DATA_W-1:0] arr_data;
    logic              af_near;
    logic              take;
    logic [CNT_W-1:0]  fill;

    assign accept = wr_en & ~wr_full;
    assign take   = rd_en & ~rd_empty;

    // Forward path: write strobe and word travel together.
    xr_delay_line #(
        .W (DATA_W + 1),
        .N (STAGES)
    ) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({accept, wr_data}),
        .dout  ({arr_valid, arr_data})
    );

    // Backward path: early-full warning returns to the producer.
    xr_delay_line #(
        .W (1),
        .N (STAGES)
    ) u_bwd (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (af_near),
        .dout  (wr_full)
    );

    xr_store #(
        .DATA_W   (DATA_W),
        .DEPTH    (DEPTH),
        .AF_LEVEL (AF_LEVEL),
        .STYLE    (STYLE)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (arr_valid),
        .wr_data     (arr_data),
        .rd_take     (take),
        .rd_data     (rd_data),
        .empty       (rd_empty),
        .almost_full (af_near),
        .fill        (fill)
    );

endmodule

// File: rtl/xr_channel_chk.sv
// Module: xr_channel_chk
// Property checker bound to xr_channel; watches storage fill and the consumer side.
// Assumes: fill and arr_valid are the storage count and the forward strobe.
module xr_channel_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_full,
    input logic              rd_en,
    input logic              rd_empty,
    input logic [DATA_W-1:0] rd_data,
    input logic              arr_valid,
    input logic [CNT_W-1:0]  fill
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_empty && !wr_full));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |-> (fill < CNT_W'(DEPTH)));

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    p_hold_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_empty && !rd_en) |=> (!rd_empty && $stable(rd_data)));

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_empty) |=> (fill == $past(fill) + CNT_W'($past(arr_valid))));

endmodule

bind xr_channel xr_channel_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_full   (wr_full),
    .rd_en     (rd_en),
    .rd_empty  (rd_empty),
    .rd_data   (rd_data),
    .arr_valid (arr_valid),
    .fill      (fill)
);

// File: tb/test_xr_channel.sv
// Bench: drives a shift-style and a ring-style channel with the same stimulus,
// checks both against a queue of accepted words and against each other.
module test_xr_channel;

    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int CROSS = 2;
    localparam int LPC   = 2;
    localparam int S     = CROSS * LPC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full_a, empty_a, full_b, empty_b;
    logic [DW-1:0] data_a, data_b;

    int            checks = 0;
    int            fails = 0;
    int            accepted = 0;
    bit            finished = 1'b0;
    logic          sm_full, sm_empty;
    logic [DW-1:0] sm_data;
    logic [DW-1:0] last_read = '0;
    logic [DW-1:0] model [$];

    always #2 clk = ~clk;

    xr_channel #(.DATA_W(DW), .DEPTH(DEPTH), .CROSSINGS(CROSS),
                 .LEVELS_PER_CROSSING(LPC), .SHIFT_MAX_DEPTH(32)) i_xr_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(full_a),
        .rd_en(rd_en), .rd_data(data_a), .rd_empty(empty_a));

    xr_channel #(.DATA_W(DW), .DEPTH(DEPTH), .CROSSINGS(CROSS),
                 .LEVELS_PER_CROSSING(LPC), .SHIFT_MAX_DEPTH(0)) i_xr_channel_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(full_b),
        .rd_en(rd_en), .rd_data(data_b), .rd_empty(empty_b));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock cycle: sample at the falling edge, model the handshake, drive inputs.
    task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r);
        @(negedge clk);
        sm_full  = full_a;
        sm_empty = empty_a;
        sm_data  = data_a;
        chk({full_a, empty_a} === {full_b, empty_b}, "R8 flags shift vs ring",
            int'({full_b, empty_b}), int'({full_a, empty_a}));
        if (!empty_a) chk(data_a === data_b, "R8 data shift vs ring", int'(data_b), int'(data_a));
        wr_en   = w;
        wr_data = d;
        rd_en   = r;
        if (w && !full_a) begin
            model.push_back(d);
            accepted++;
        end
        if (r && !empty_a) begin
            if (model.size() == 0) begin
                chk(1'b0, "R6 word with empty model", int'(data_a), -1);
            end else begin
                chk(data_a === model[0], "R6 order", int'(data_a), int'(model[0]));
                last_read = model.pop_front();
            end
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) cyc(1'b0, '0, 1'b0);
        rst_n = 1'b1;

        // R1: reset state
        cyc(1'b0, '0, 1'b0);
        chk(sm_empty === 1'b1, "R1 empty after reset", int'(sm_empty), 1);
        chk(sm_full === 1'b0, "R1 full after reset", int'(sm_full), 0);

        // R4: forward latency of one word into an empty channel
        cyc(1'b1, 16'hA5A5, 1'b0);
        for (int k = 1; k <= S + 1; k++) begin
            cyc(1'b0, '0, 1'b0);
            if (k == S)     chk(sm_empty === 1'b1, "R4 still empty at S-1", int'(sm_empty), 1);
            if (k == S + 1) begin
                chk(sm_empty === 1'b0, "R4 word visible at S", int'(sm_empty), 0);
                chk(sm_data === 16'hA5A5, "R4 first word", int'(sm_data), 'hA5A5);
            end
        end
        cyc(1'b0, '0, 1'b1);
        cyc(1'b0, '0, 1'b0);

        // R7: reads while empty do not consume a later word
        repeat (4) cyc(1'b0, '0, 1'b1);
        cyc(1'b1, 16'h1234, 1'b1);
        for (int k = 1; k <= S; k++) cyc(1'b0, '0, 1'b1);
        cyc(1'b0, '0, 1'b0);
        chk(sm_empty === 1'b0, "R7 word kept after empty reads", int'(sm_empty), 0);
        chk(sm_data === 16'h1234, "R7 head word", int'(sm_data), 'h1234);
        cyc(1'b0, '0, 1'b1);
        cyc(1'b0, '0, 1'b0);
        chk(model.size() == 0, "R7 model drained", model.size(), 0);

        // R3/R2: continuous writes from empty fill exactly DEPTH words
        accepted = 0;
        for (int i = 0; i < DEPTH + 2 * S + 6; i++) cyc(1'b1, DW'(16'h0100 + i), 1'b0);
        repeat (S + 2) cyc(1'b0, '0, 1'b0);
        chk(accepted == DEPTH, "R3 words accepted before full", accepted, DEPTH);
        chk(sm_full === 1'b1, "R2 full held with storage loaded", int'(sm_full), 1);

        // R5: full drops S edges after fill goes below the threshold
        for (int j = 0; j < 2 * S + 1; j++) cyc(1'b0, '0, 1'b1);
        for (int k = 1; k <= S + 1; k++) begin
            cyc(1'b0, '0, 1'b0);
            if (k == S)     chk(sm_full === 1'b1, "R5 full still high at S-1", int'(sm_full), 1);
            if (k == S + 1) chk(sm_full === 1'b0, "R5 full low at S", int'(sm_full), 0);
        end
        for (int g = 0; g < 40 && model.size() > 0; g++) cyc(1'b0, '0, 1'b1);
        chk(last_read === DW'(16'h0100 + DEPTH - 1), "R2 no word written while full",
            int'(last_read), 'h0100 + DEPTH - 1);
        cyc(1'b0, '0, 1'b0);
        chk(sm_empty === 1'b1, "R2 nothing extra stored", int'(sm_empty), 1);

        // R6: random producer stalls and consumer backpressure
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 10) < 6, DW'($urandom), ($urandom % 10) < 5);
        for (int g = 0; g < 200; g++) cyc(1'b0, '0, 1'b1);
        cyc(1'b0, '0, 1'b0);
        chk(model.size() == 0, "R6 no word lost", model.size(), 0);
        chk(sm_empty === 1'b1, "R6 no word duplicated", int'(sm_empty), 1);

        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule